// File: doc/BRIEF.md
# Asynchronous Character Receiver with Break Detection

This block receives asynchronous serial characters. Each character has a low start bit, five to eight data bits sent least significant bit first, and one stop bit. The serial line is sampled on a receive tick. The tick is an enable that runs at a selectable multiple of the bit rate. When the stop bit has been sampled, the assembled character is placed in a holding register and a ready flag is raised. The host clears the flag with a read strobe. If the host has not read the previous character when the next one completes, the new character overwrites it and a sticky overrun flag is set.

The block also recognises a break condition. This is a frame in which the line stays low through every data position and through the stop position. It is reported on a dedicated output and does not load the holding register. After any frame whose stop position is sampled low, the receiver waits for the line to return high before it looks for the next start bit.

Top module: `async_char_rx`

## Requirements
- R1: A high `rst` sampled on a clock edge clears `rx_ready`, `overrun`, `line_break` and `rx_data` to zero, and returns the receiver to idle.
- R2: `rate_sel` selects receive ticks per bit: 00 gives 1, 01 gives 16, 10 and 11 give 64.
- R3: At rates 16 and 64, a low line seen at a tick in idle is sampled again N/2 ticks later. If the line is high at that point, the start is discarded and no character is produced.
- R4: Data bits arrive least significant bit first. `len_sel` 00, 01, 10 and 11 select 5, 6, 7 and 8 bits. The character is right-aligned in `rx_data` and the unused upper bits are zero.
- R5: `rx_ready` rises on the edge that samples the stop bit. For rate N and length L, that edge is N/2 + N·(L+1) ticks after the tick that first saw the start; at rate 1 it is L+1 ticks after. `rx_ready` falls on the edge that samples `rd_strobe` high. `rx_data` changes only when a character is loaded.
- R6: If a character completes while `rx_ready` is set and `rd_strobe` is low in that cycle, the new character replaces the old one and `overrun` is set.
- R7: `overrun` stays set until an edge samples `err_clr` high or reset. A new overrun in the same cycle takes precedence over `err_clr`.
- R8: A frame whose data bits and stop bit are all sampled low sets `line_break` and leaves `rx_ready` and `rx_data` unchanged. A frame with a low stop bit but nonzero data is still loaded.
- R9: After a stop bit sampled low, no new start is accepted until a tick sees the line high. `line_break` clears on that tick.
- R10: Clock cycles with `rx_tick` low advance no receiver state, so no flag can rise in them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_tick | input | 1 | Receive tick enable, one pulse per receive clock period |
| rx_line | input | 1 | Serial input, idle high |
| rate_sel | input | 2 | Ticks-per-bit select |
| len_sel | input | 2 | Character length select |
| rd_strobe | input | 1 | Host read of the holding register |
| err_clr | input | 1 | Clears the overrun flag |
| rx_data | output | 8 | Holding register, right-aligned character |
| rx_ready | output | 1 | Character waiting |
| overrun | output | 1 | Sticky loss-of-character flag |
| line_break | output | 1 | Break condition seen on the line |

## Verification
The bench uses the package defaults: 8-bit maximum length and a 64-tick maximum rate. For most of the run the tick is held high every cycle, so one receive tick equals one clock. At rate 1 every code of every length is swept. At rate 16 every third code is swept, and at rate 64 a set of edge patterns. The stop-sample edge is checked to the exact cycle in every swept frame. Short runs with a divided tick and with no ticks at all exercise the tick gating. Directed frames cover false starts, overrun, break and the low-stop-bit case.

// File: rtl/async_rx_pkg.sv
package async_rx_pkg;

    localparam int MAX_LEN    = 8;
    localparam int MAX_FACTOR = 64;
    localparam int CNT_W      = $clog2(MAX_FACTOR);
    localparam int LEN_W      = $clog2(MAX_LEN + 1);
    localparam int MIN_LEN    = 5;

    localparam logic [1:0] RATE_X1  = 2'b00;
    localparam logic [1:0] RATE_X16 = 2'b01;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_STOP,
        ST_WAIT
    } rx_state_e;

    // Outcome of one frame at its stop sample
    typedef struct packed {
        logic [MAX_LEN-1:0] data;
        logic               stop_high;
        logic               data_zero;
    } rx_frame_t;

    // Last counter value of a full bit period
    function automatic logic [CNT_W-1:0] full_limit(input logic [1:0] rate);
        case (rate)
            RATE_X1:  full_limit = CNT_W'(0);
            RATE_X16: full_limit = CNT_W'(15);
            default:  full_limit = CNT_W'(MAX_FACTOR - 1);
        endcase
    endfunction

    // Last counter value before the start-bit midpoint
    function automatic logic [CNT_W-1:0] half_limit(input logic [1:0] rate);
        case (rate)
            RATE_X16: half_limit = CNT_W'(7);
            default:  half_limit = CNT_W'(MAX_FACTOR / 2 - 1);
        endcase
    endfunction

    function automatic logic [LEN_W-1:0] char_bits(input logic [1:0] len);
        char_bits = LEN_W'(MIN_LEN) + LEN_W'(len);
    endfunction

endpackage

// File: rtl/rx_bit_timer.sv
module rx_bit_timer
    import async_rx_pkg::*;
#(
    parameter int W = CNT_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  logic         restart,
    input  logic [W-1:0] limit,
    output logic         hit
);

    logic [W-1:0] cnt;

    assign hit = tick && !restart && (cnt == limit);

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= hit ? '0 : cnt + W'(1);
        end
    end

endmodule

// File: rtl/rx_shifter.sv
module rx_shifter
    import async_rx_pkg::*;
#(
    parameter int DW = MAX_LEN,
    parameter int LW = LEN_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clear,
    input  logic          shift_en,
    input  logic          bit_in,
    input  logic [LW-1:0] len,
    output logic [DW-1:0] aligned
);

    logic [DW-1:0] sh;
    logic [LW-1:0] shamt;

    // Bits enter at the top, so the first (least significant) bit ends lowest
    always_ff @(posedge clk) begin
        if (rst || clear) begin
            sh <= '0;
        end else if (shift_en) begin
            sh <= {bit_in, sh[DW-1:1]};
        end
    end

    assign shamt   = LW'(DW) - len;
    assign aligned = sh >> shamt;

endmodule

// File: rtl/rx_holding.sv
module rx_holding
    import async_rx_pkg::*;
#(
    parameter int DW = MAX_LEN
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [DW-1:0] load_data,
    input  logic          rd,
    input  logic          err_clr,
    output logic [DW-1:0] data,
    output logic          ready,
    output logic          ovr
);

    always_ff @(posedge clk) begin
        if (rst) begin
            data  <= '0;
            ready <= 1'b0;
            ovr   <= 1'b0;
        end else begin
            if (load) begin
                data  <= load_data;
                ready <= 1'b1;
            end else if (rd) begin
                ready <= 1'b0;
            end
            if (load && ready && !rd) begin
                ovr <= 1'b1;
            end else if (err_clr) begin
                ovr <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/async_char_rx.sv
module async_char_rx
    import async_rx_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               rx_tick,
    input  logic               rx_line,
    input  logic [1:0]         rate_sel,
    input  logic [1:0]         len_sel,
    input  logic               rd_strobe,
    input  logic               err_clr,
    output logic [MAX_LEN-1:0] rx_data,
    output logic               rx_ready,
    output logic               overrun,
    output logic               line_break
);

    rx_state_e          state;
    logic [LEN_W-1:0]   bit_idx;
    logic [LEN_W-1:0]   len;
    logic [CNT_W-1:0]   limit;
    logic               restart;
    logic               hit;
    logic               detect;
    logic               stop_hit;
    logic               load;
    logic               brk_set;
    logic               brk_q;
    logic [MAX_LEN-1:0] aligned;
    rx_frame_t          frame;

    assign len     = char_bits(len_sel);
    assign limit   = (state == ST_START) ? half_limit(rate_sel) : full_limit(rate_sel);
    assign restart = (state == ST_IDLE) || (state == ST_WAIT);
    assign detect  = (state == ST_IDLE) && rx_tick && !rx_line;

    rx_bit_timer #(.W(CNT_W)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .tick    (rx_tick),
        .restart (restart),
        .limit   (limit),
        .hit     (hit)
    );

    rx_shifter #(.DW(MAX_LEN), .LW(LEN_W)) u_shift (
        .clk      (clk),
        .rst      (rst),
        .clear    (detect),
        .shift_en ((state == ST_DATA) && hit),
        .bit_in   (rx_line),
        .len      (len),
        .aligned  (aligned)
    );

    always_comb begin
        frame.data      = aligned;
        frame.stop_high = rx_line;
        frame.data_zero = (aligned == '0);
    end

    assign stop_hit = (state == ST_STOP) && hit;
    assign brk_set  = stop_hit && !frame.stop_high && frame.data_zero;
    assign load     = stop_hit && !brk_set;

    rx_holding #(.DW(MAX_LEN)) u_hold (
        .clk       (clk),
        .rst       (rst),
        .load      (load),
        .load_data (frame.data),
        .rd        (rd_strobe),
        .err_clr   (err_clr),
        .data      (rx_data),
        .ready     (rx_ready),
        .ovr       (overrun)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            bit_idx <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    bit_idx <= '0;
                    if (detect) begin
                        state <= (rate_sel == RATE_X1) ? ST_DATA : ST_START;
                    end
                end
                ST_START: if (hit) begin
                    state <= rx_line ? ST_IDLE : ST_DATA;
                end
                ST_DATA: if (hit) begin
                    if (bit_idx == len - LEN_W'(1)) begin
                        state <= ST_STOP;
                    end else begin
                        bit_idx <= bit_idx + LEN_W'(1);
                    end
                end
                ST_STOP: if (hit) begin
                    state <= frame.stop_high ? ST_IDLE : ST_WAIT;
                end
                ST_WAIT: if (rx_tick && rx_line) begin
                    state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            brk_q <= 1'b0;
        end else if (brk_set) begin
            brk_q <= 1'b1;
        end else if ((state == ST_WAIT) && rx_tick && rx_line) begin
            brk_q <= 1'b0;
        end
    end

    assign line_break = brk_q;

endmodule

// File: rtl/rx_checker.sv
module rx_checker
    import async_rx_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               rx_tick,
    input logic               rx_line,
    input logic               rd_strobe,
    input logic               err_clr,
    input logic [MAX_LEN-1:0] rx_data,
    input logic               rx_ready,
    input logic               overrun,
    input logic               line_break
);

    p_reset_clears_r1: assert property (@(posedge clk)
        rst |=> (!rx_ready && !overrun && !line_break && rx_data == '0));

    p_ready_falls_on_read_r5: assert property (@(posedge clk) disable iff (rst)
        $fell(rx_ready) |-> $past(rd_strobe));

    p_data_moves_with_ready_r5: assert property (@(posedge clk) disable iff (rst)
        !$stable(rx_data) |-> rx_ready);

    p_overrun_keeps_char_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(overrun) |-> (rx_ready && $past(rx_ready)));

    p_overrun_sticky_r7: assert property (@(posedge clk) disable iff (rst)
        (overrun && !err_clr) |=> overrun);

    p_break_no_load_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(line_break) |-> !$rose(rx_ready));

    p_break_holds_r9: assert property (@(posedge clk) disable iff (rst)
        (line_break && !(rx_tick && rx_line)) |=> line_break);

    p_no_tick_no_flag_r10: assert property (@(posedge clk) disable iff (rst)
        !rx_tick |=> (!$rose(rx_ready) && !$rose(line_break)));

endmodule

bind async_char_rx rx_checker u_rx_checker (
    .clk        (clk),
    .rst        (rst),
    .rx_tick    (rx_tick),
    .rx_line    (rx_line),
    .rd_strobe  (rd_strobe),
    .err_clr    (err_clr),
    .rx_data    (rx_data),
    .rx_ready   (rx_ready),
    .overrun    (overrun),
    .line_break (line_break)
);

// File: tb/tb_async_char_rx.sv
module tb_async_char_rx;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rx_tick = 1'b1;
    logic       rx_line = 1'b1;
    logic [1:0] rate_sel = 2'b00;
    logic [1:0] len_sel = 2'b00;
    logic       rd_strobe = 1'b0;
    logic       err_clr = 1'b0;
    logic [7:0] rx_data;
    logic       rx_ready;
    logic       overrun;
    logic       line_break;

    int total = 0;
    int bad = 0;
    int per = 1;
    int tc = 0;
    bit tick_off = 1'b0;

    always #10 clk = ~clk;

    async_char_rx dut (
        .clk        (clk),
        .rst        (rst),
        .rx_tick    (rx_tick),
        .rx_line    (rx_line),
        .rate_sel   (rate_sel),
        .len_sel    (len_sel),
        .rd_strobe  (rd_strobe),
        .err_clr    (err_clr),
        .rx_data    (rx_data),
        .rx_ready   (rx_ready),
        .overrun    (overrun),
        .line_break (line_break)
    );

    always @(negedge clk) begin
        tc = (tc + 1 >= per) ? 0 : tc + 1;
        rx_tick = !tick_off && (tc == 0);
    end

    function automatic int fac(input int r);
        return (r == 0) ? 1 : (r == 1) ? 16 : 64;
    endfunction

    task automatic chk(input string req, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Entered and left at a falling clock edge
    task automatic send(input int rate, input int lcode, input int d, input bit stop,
                        input bit exact, input int tail_low);
        int n    = fac(rate);
        int l    = lcode + 5;
        int dm   = d & ((1 << l) - 1);
        int half = n / 2;
        int hold = n * per;
        rate_sel = 2'(rate);
        len_sel  = 2'(lcode);
        rx_line  = 1'b0;
        repeat (hold) @(negedge clk);
        for (int k = 0; k < l; k++) begin
            rx_line = 1'((dm >> k) & 1);
            repeat (hold) @(negedge clk);
        end
        rx_line = stop;
        if (exact) begin
            repeat (half) @(negedge clk);
            chk("R5", "ready before stop sample", rx_ready, 0);
            chk("R8", "break before stop sample", line_break, 0);
            @(negedge clk);
            if (stop || dm != 0) begin
                chk("R5", "ready at stop sample", rx_ready, 1);
                chk("R4", "character value", rx_data, dm);
                chk("R6", "no overrun", overrun, 0);
            end else begin
                chk("R8", "break at stop sample", line_break, 1);
                chk("R8", "break not loaded", rx_ready, 0);
            end
            repeat (n - half - 1) @(negedge clk);
        end else begin
            repeat (hold) @(negedge clk);
        end
        if (tail_low > 0) begin
            rx_line = 1'b0;
            repeat (tail_low) @(negedge clk);
        end else begin
            rx_line = 1'b1;
            repeat (2 * per) @(negedge clk);
        end
    endtask

    task automatic do_read();
        rd_strobe = 1'b1;
        @(negedge clk);
        rd_strobe = 1'b0;
        chk("R5", "ready cleared by read", rx_ready, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        idle(4);
        chk("R1", "reset ready", rx_ready, 0);
        chk("R1", "reset overrun", overrun, 0);
        chk("R1", "reset break", line_break, 0);
        chk("R1", "reset data", rx_data, 0);
        rst = 1'b0;
        idle(3);

        // R2 R4 rate 1, every code of every length
        for (int lc = 0; lc < 4; lc++)
            for (int d = 0; d < (1 << (lc + 5)); d++) begin
                send(0, lc, d, 1'b1, 1'b1, 0);
                do_read();
            end
        // R2 R4 rate 16, every third code
        for (int lc = 0; lc < 4; lc++)
            for (int d = 0; d < (1 << (lc + 5)); d += 3) begin
                send(1, lc, d, 1'b1, 1'b1, 0);
                do_read();
            end
        // R2 R4 rate 64, edge patterns
        for (int lc = 0; lc < 4; lc++)
            for (int i = 0; i < 8; i++) begin
                int pat[8] = '{8'h00, 8'hFF, 8'hA5, 8'h5A, 8'h01, 8'h80, 8'h3C, 8'hC3};
                send(2, lc, pat[i], 1'b1, 1'b1, 0);
                do_read();
            end
        // R2 code 11 behaves as rate 64
        send(3, 3, 8'hC3, 1'b1, 1'b1, 0);
        do_read();
        send(3, 0, 8'h15, 1'b1, 1'b1, 0);
        do_read();

        // R3 false starts
        rate_sel = 2'b01; len_sel = 2'b11;
        rx_line = 1'b0; idle(4); rx_line = 1'b1; idle(40);
        chk("R3", "short low at rate 16 ignored", rx_ready, 0);
        rate_sel = 2'b10;
        rx_line = 1'b0; idle(20); rx_line = 1'b1; idle(120);
        chk("R3", "short low at rate 64 ignored", rx_ready, 0);
        send(1, 3, 8'h6B, 1'b1, 1'b1, 0);
        do_read();

        // R6 R7 overrun
        send(1, 3, 8'h11, 1'b1, 1'b1, 0);
        send(1, 3, 8'h22, 1'b1, 1'b0, 0);
        chk("R6", "overrun set", overrun, 1);
        chk("R6", "newer char kept", rx_data, 8'h22);
        chk("R6", "ready stays", rx_ready, 1);
        do_read();
        chk("R7", "overrun survives read", overrun, 1);
        idle(50);
        chk("R7", "overrun survives idle", overrun, 1);
        err_clr = 1'b1; @(negedge clk); err_clr = 1'b0;
        chk("R7", "overrun cleared", overrun, 0);

        // R1 reset after flags are set
        send(0, 3, 8'h33, 1'b1, 1'b1, 0);
        send(0, 3, 8'h44, 1'b1, 1'b0, 0);
        chk("R6", "overrun at rate 1", overrun, 1);
        rst = 1'b1; idle(2); rst = 1'b0;
        chk("R1", "reset clears ready", rx_ready, 0);
        chk("R1", "reset clears overrun", overrun, 0);
        chk("R1", "reset clears data", rx_data, 0);
        idle(2);

        // R8 R9 break
        send(1, 3, 0, 1'b0, 1'b1, 100);
        chk("R9", "break held while low", line_break, 1);
        chk("R9", "no char while low", rx_ready, 0);
        rx_line = 1'b1; idle(2);
        chk("R9", "break cleared by high line", line_break, 0);
        send(1, 3, 8'h81, 1'b1, 1'b1, 0);
        do_read();
        // R8 low stop with nonzero data still loads
        send(1, 3, 8'h5A, 1'b0, 1'b1, 0);
        chk("R8", "no break on nonzero data", line_break, 0);
        do_read();

        // R10 divided tick and no tick
        per = 3;
        idle(6);
        send(1, 3, 8'h96, 1'b1, 1'b0, 0);
        chk("R10", "char with divided tick", rx_ready, 1);
        chk("R10", "value with divided tick", rx_data, 8'h96);
        do_read();
        per = 1;
        tick_off = 1'b1;
        idle(2);
        rx_line = 1'b0; idle(200);
        chk("R10", "no char without ticks", rx_ready, 0);
        chk("R10", "no break without ticks", line_break, 0);
        rx_line = 1'b1; idle(4);
        tick_off = 1'b0; idle(4);
        send(1, 2, 8'h4D, 1'b1, 1'b1, 0);
        do_read();

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule